// File: doc/BRIEF.md
# Frame-Aligned Slip Buffer with Event Status

This block is an elastic store for framed octet streams in which each frame carries 24 channel octets. Octets enter through a write port and leave through a read port, both in one clock domain. The buffer holds two complete frames. When the producer and the consumer drift apart, the buffer does not lose single octets. It slips by a whole frame instead, so each octet that leaves keeps its channel position within the frame.

An overflow discards the oldest stored frame. An underflow plays back the most recently emptied frame. Each slip is latched into an 8-bit status register that a host can poll or use to raise an interrupt. A host read clears the register. A host write clears only the bits written as one. A separate enable register selects which status bits drive the interrupt line.

Stream rules: the write side has no ready signal. An octet is accepted in every cycle where `wr_valid` is high, and a full buffer makes room by slipping. The read side is pulled by `rd_ready` and never stalls. One octet is delivered for every cycle where `rd_ready` is high, and it appears with `rd_valid` on the following cycle. If nothing new is stored, that octet is a repeated one.

Top module: `frame_slip_buffer`

## Requirements
- R1: Octets leave in the order they were written. `rd_sof` is 1 exactly when the delivered octet sits at channel position 0 of its frame. Storage positions count from 0 after reset, and position p holds channel p mod 24.
- R2: A write while 48 octets are held and no read is requested drops the 24 oldest octets and then stores the new one. Reading then continues 24 positions further on.
- R3: A read while the buffer is empty steps back 24 positions. It delivers the octet stored there and then the rest of that frame again.
- R4: Status bit 7 sets on every overflow slip (R2).
- R5: Status bit 6 sets on every underflow slip (R3).
- R6: Status bit 5 sets on either kind of slip. Set bits stay set until they are cleared.
- R7: After reset the status register, the enable register, `irq_o` and `rd_valid` are all 0.
- R8: A pulse on `stat_rd` clears all status bits. `stat_q` shows the value the register held before the clear.
- R9: A pulse on `stat_wr` clears exactly the status bits that are 1 in `stat_wdata`.
- R10: An event in the same cycle as a clear survives. The event's bits read 1 afterwards.
- R11: Status bits 4 to 0 always read 0, whatever is written.
- R12: `irq_o` is 1 exactly when some status bit and its enable bit are both 1. The enable register is loaded from `en_wdata` on `en_wr`.
- R13: `rd_valid` is 1 in the cycle after each cycle where `rd_ready` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write one octet this cycle |
| wr_data | input | 8 | Octet to store |
| rd_ready | input | 1 | Request one octet this cycle |
| rd_valid | output | 1 | Delivered octet present |
| rd_data | output | 8 | Delivered octet |
| rd_sof | output | 1 | Delivered octet is channel 0 of a frame |
| stat_rd | input | 1 | Host read strobe; clears status |
| stat_wr | input | 1 | Host write strobe; clears bits set in data |
| stat_wdata | input | 8 | Write-one-to-clear mask |
| stat_q | output | 8 | Status register |
| en_wr | input | 1 | Load interrupt enables |
| en_wdata | input | 8 | Interrupt enable value |
| irq_o | output | 1 | Active-high interrupt |

## Verification
Two functions can fall in the same cycle: a slip event can set a status bit while a host read or write-one clear removes bits. The bench provokes this by keeping the buffer near full or near empty with biased random traffic, while clear strobes arrive at random. In each cycle it compares the whole status byte against a model. That model clears first and then sets the bits of any slip that happens in the same cycle. Read-side data and frame markers are compared across every slip against a model store that follows the delete and replay rules.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
  localparam int unsigned ST_FULL  = 7;
  localparam int unsigned ST_EMPTY = 6;
  localparam int unsigned ST_SLIP  = 5;

  typedef struct packed {
    logic over;
    logic under;
  } slip_ev_t;
endpackage

// File: rtl/fsb_ctrl.sv
module fsb_ctrl
  import fsb_pkg::*;
#(
  parameter int unsigned FRAME  = 24,
  parameter int unsigned FRAMES = 2,
  localparam int unsigned DEPTH = FRAME * FRAMES,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output slip_ev_t      ev
);
  localparam logic [AW-1:0] FR_A  = AW'(FRAME);
  localparam logic [AW-1:0] DEP_A = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FR_C  = CW'(FRAME);
  localparam logic [CW-1:0] DEP_C = CW'(DEPTH);

  logic [AW-1:0] wp, rp, back, fwd;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] a);
    return (a == DEP_A) ? '0 : a + 1'b1;
  endfunction

  always_comb begin
    ev.over  = wr_valid && !rd_ready && (cnt == DEP_C);
    ev.under = rd_ready && (cnt == '0);
    back     = (rp >= FR_A) ? rp - FR_A : rp + (DEP_A + 1'b1 - FR_A);
    fwd      = (rp >= (DEP_A + 1'b1 - FR_A)) ? rp - (DEP_A + 1'b1 - FR_A) : rp + FR_A;
    rd_addr  = ev.under ? back : rp;
    wr_addr  = wp;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_valid) wp <= inc(wp);
      if (ev.under) begin
        rp  <= inc(back);
        cnt <= FR_C - 1'b1 + CW'(wr_valid);
      end else if (rd_ready) begin
        rp  <= inc(rp);
        cnt <= cnt - 1'b1 + CW'(wr_valid);
      end else if (ev.over) begin
        rp  <= fwd;
        cnt <= cnt - FR_C + 1'b1;
      end else begin
        cnt <= cnt + CW'(wr_valid);
      end
    end
  end

  p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n) cnt <= DEP_C);
  p_drop_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev.over |=> cnt == FR_C + 1'b1);
  p_replay_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev.under |=> (cnt == FR_C - 1'b1) || (cnt == FR_C));
  p_slip_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev.over && ev.under));
endmodule

// File: rtl/fsb_mem.sv
module fsb_mem #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned FRAME = 24,
  parameter int unsigned DEPTH = 48,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_sof
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else if (we) begin
      store[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_sof   <= 1'b0;
    end else begin
      rd_valid <= re;
      if (re) begin
        rd_data <= store[raddr];
        rd_sof  <= (32'(raddr) % FRAME) == 0;
      end
    end
  end

  p_valid_follows_r13: assert property (@(posedge clk) disable iff (!rst_n)
    re |=> rd_valid);
  p_valid_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> !rd_valid);
endmodule

// File: rtl/fsb_status.sv
module fsb_status
  import fsb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  slip_ev_t   ev,
  input  logic       stat_rd,
  input  logic       stat_wr,
  input  logic [7:0] stat_wdata,
  input  logic       en_wr,
  input  logic [7:0] en_wdata,
  output logic [7:0] stat_q,
  output logic       irq_o
);
  localparam logic [7:0] LIVE = 8'b1110_0000;

  logic [7:0] set_v, clr_v, en_q;

  always_comb begin
    set_v           = '0;
    set_v[ST_FULL]  = ev.over;
    set_v[ST_EMPTY] = ev.under;
    set_v[ST_SLIP]  = ev.over | ev.under;
    clr_v           = (stat_rd ? 8'hFF : 8'h00) | (stat_wr ? stat_wdata : 8'h00);
  end

  for (genvar b = 0; b < 8; b++) begin : g_bit
    if (LIVE[b]) begin : g_live
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stat_q[b] <= 1'b0;
          en_q[b]   <= 1'b0;
        end else begin
          stat_q[b] <= (stat_q[b] & ~clr_v[b]) | set_v[b];
          if (en_wr) en_q[b] <= en_wdata[b];
        end
      end
    end else begin : g_rsvd
      assign stat_q[b] = 1'b0;
      assign en_q[b]   = 1'b0;
    end
  end

  assign irq_o = |(stat_q & en_q);

  p_full_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev.over |=> stat_q[ST_FULL]);
  p_empty_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev.under |=> stat_q[ST_EMPTY]);
  p_slip_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.over || ev.under) |=> stat_q[ST_SLIP]);
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ev.over && !ev.under) |=> stat_q == 8'h00);
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_rd && !stat_wr) |=> (stat_q & $past(stat_q)) == $past(stat_q));
endmodule

// File: rtl/frame_slip_buffer.sv
module frame_slip_buffer
  import fsb_pkg::*;
#(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned FRAME  = 24,
  parameter int unsigned FRAMES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_ready,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_sof,
  input  logic             stat_rd,
  input  logic             stat_wr,
  input  logic [7:0]       stat_wdata,
  output logic [7:0]       stat_q,
  input  logic             en_wr,
  input  logic [7:0]       en_wdata,
  output logic             irq_o
);
  localparam int unsigned DEPTH = FRAME * FRAMES;
  localparam int unsigned AW    = $clog2(DEPTH);

  logic [AW-1:0] waddr, raddr;
  slip_ev_t      ev;

  fsb_ctrl #(.FRAME(FRAME), .FRAMES(FRAMES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rd_ready(rd_ready),
    .wr_addr(waddr), .rd_addr(raddr), .ev(ev)
  );

  fsb_mem #(.WIDTH(WIDTH), .FRAME(FRAME), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(wr_valid), .waddr(waddr), .wdata(wr_data),
    .re(rd_ready), .raddr(raddr), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_sof(rd_sof)
  );

  fsb_status u_stat (
    .clk(clk), .rst_n(rst_n), .ev(ev), .stat_rd(stat_rd), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .en_wr(en_wr), .en_wdata(en_wdata),
    .stat_q(stat_q), .irq_o(irq_o)
  );
endmodule

// File: tb/frame_slip_buffer_test.sv
module frame_slip_buffer_test;
  localparam int FR = 24;
  localparam int DP = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 0, rd_ready = 0, stat_rd = 0, stat_wr = 0, en_wr = 0;
  logic [7:0] wr_data = 0, stat_wdata = 0, en_wdata = 0;
  logic rd_valid, rd_sof, irq_o;
  logic [7:0] rd_data, stat_q;

  always #5 clk = ~clk;

  frame_slip_buffer uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data), .rd_sof(rd_sof),
    .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_wdata(stat_wdata), .stat_q(stat_q),
    .en_wr(en_wr), .en_wdata(en_wdata), .irq_o(irq_o)
  );

  int n_chk = 0, n_bad = 0;
  int m_mem [DP];
  int m_wp = 0, m_rp = 0, m_cnt = 0;
  logic [7:0] m_st = 0, m_en = 0;
  logic e_v = 0, e_sof = 0;
  logic [7:0] e_d = 0;
  string dtag = "R1";
  int n_over = 0, n_under = 0, n_clash = 0;
  bit done = 0;

  task automatic chk(input int act, input int exp, input string tag, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] st_next(input logic [7:0] s, input bit srd, input bit swr,
                                         input logic [7:0] wd, input bit ov, input bit un);
    logic [7:0] r;
    r = s & ~(srd ? 8'hFF : 8'h00) & ~(swr ? wd : 8'h00);
    if (ov) r = r | 8'hA0;
    if (un) r = r | 8'h60;
    return r & 8'hE0;
  endfunction

  task automatic step(input bit w, input logic [7:0] d, input bit r, input bit srd,
                      input bit swr, input logic [7:0] swd, input bit ewr, input logic [7:0] ewd);
    bit ov, un;
    int a;
    string stag;
    wr_valid = w; wr_data = d; rd_ready = r; stat_rd = srd; stat_wr = swr;
    stat_wdata = swd; en_wr = ewr; en_wdata = ewd;
    ov = w && !r && (m_cnt == DP);
    un = r && (m_cnt == 0);
    e_v = r;
    if (un) begin
      a = (m_rp + FR) % DP;
      e_d = m_mem[a][7:0]; e_sof = (a % FR) == 0;
      m_rp = (a + 1) % DP; m_cnt = FR - 1;
    end else if (r) begin
      e_d = m_mem[m_rp][7:0]; e_sof = (m_rp % FR) == 0;
      m_rp = (m_rp + 1) % DP; m_cnt--;
    end else if (ov) begin
      m_rp = (m_rp + FR) % DP; m_cnt -= FR;
    end
    if (w) begin m_mem[m_wp] = d; m_wp = (m_wp + 1) % DP; m_cnt++; end
    if ((srd || swr) && (ov || un)) n_clash++;
    if (ov) n_over++;
    if (un) n_under++;
    stag = (srd || swr) ? ((ov || un) ? "R10" : (srd ? "R8" : "R9")) : "R6";
    m_st = st_next(m_st, srd, swr, swd, ov, un);
    if (ewr) m_en = ewd & 8'hE0;
    @(posedge clk);
    @(negedge clk);
    chk(rd_valid, e_v, "R13", "rd_valid");
    if (e_v) begin
      chk(rd_data, e_d, dtag, "rd_data");
      chk(rd_sof, e_sof, "R1", "rd_sof");
    end
    chk(stat_q, m_st, stag, "stat_q");
    chk(stat_q[4:0], 0, "R11", "reserved bits");
    chk(irq_o, |(m_st & m_en), "R12", "irq_o");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DP; i++) m_mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(stat_q, 0, "R7", "reset status");
    chk(irq_o, 0, "R7", "reset irq");
    chk(rd_valid, 0, "R7", "reset rd_valid");

    // R1: fill one frame, drain partly in order
    for (int i = 0; i < 30; i++) step(1, 8'(i + 1), 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 0, 0, 0, 0);
    // R2: fill to 48 then overflow
    for (int i = 0; i < 23; i++) step(1, 8'(i + 100), 0, 0, 0, 0, 0, 0);
    step(1, 8'hEE, 0, 0, 0, 0, 1, 8'h80);
    chk(stat_q[7], 1, "R4", "full bit");
    chk(stat_q[5], 1, "R6", "slip bit");
    chk(irq_o, 1, "R12", "irq on enabled full");
    dtag = "R2";
    for (int i = 0; i < 25; i++) step(0, 0, 1, 0, 0, 0, 0, 0);
    // R8: read clears
    step(0, 0, 0, 1, 0, 0, 0, 0);
    chk(stat_q, 0, "R8", "cleared by read");
    // R3: underflow replay
    dtag = "R3";
    for (int i = 0; i < 30; i++) step(0, 0, 1, 0, 0, 0, 0, 0);
    chk(stat_q[6], 1, "R5", "empty bit");
    chk(stat_q[7], 0, "R5", "full bit stays clear");
    // R9: write-one clears only bit 6
    step(0, 0, 0, 0, 1, 8'h5F, 0, 0);
    chk(stat_q, 8'h20, "R9", "write-one clear");
    dtag = "R1";

    // constrained random, biased phases
    for (int ph = 0; ph < 8; ph++) begin
      for (int i = 0; i < 1500; i++) begin
        bit w, r;
        w = ($urandom % 100) < ((ph % 2 == 0) ? 75 : 30);
        r = ($urandom % 100) < ((ph % 2 == 0) ? 30 : 75);
        step(w, 8'($urandom), r, ($urandom % 12) == 0, ($urandom % 12) == 0,
             8'($urandom), ($urandom % 40) == 0, 8'($urandom));
      end
    end
    chk(int'(n_over > 0), 1, "R2", "overflows seen");
    chk(int'(n_under > 0), 1, "R3", "underflows seen");
    chk(int'(n_clash > 0), 1, "R10", "clear/event clashes seen");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule